// File: doc/BRIEF.md
# Programmable horizontal sync generator

This block derives horizontal line timing from a pixel clock. A line counter advances on every clock where the pixel enable is high. It runs from 1 up to a programmed line total, then starts over at 1. The horizontal sync pulse, which is active low, opens in the same cycle that the counter starts over. It stays asserted for a programmed number of pixels. A one-cycle start-of-line strobe marks every restart.

The block also drives a digital sync level for the adder that feeds a video DAC. The level is a programmed amplitude code multiplied by a fixed step, and it is non-zero only while sync is asserted. The line total, the sync width and the amplitude are each captured only at a line start. Software can therefore rewrite them at any time without producing a torn line.

After reset, or after a synchronous clear, the counter sits at 0. This is an idle pre-line state. The next enabled clock opens the first line.

Top module: `hsync_gen`

## Requirements
- R1: While reset is asserted, and after it, the outputs are: count 0, hsync_no high, sol_o low and level_o 0.
- R2: An enabled clock loads the count to 1 and raises sol_o for exactly one cycle when the count is 0 or equals the captured line total. Otherwise sol_o is low.
- R3: An enabled clock increments the count by one when the count is between 1 and one less than the captured total. A clock with pix_en_i low leaves the count unchanged.
- R4: hsync_no is low exactly when the count is between 1 and the captured sync width, inclusive. It is therefore low in the cycle where sol_o is high, unless the width is 0.
- R5: A captured sync width of 0 keeps hsync_no high for the entire line. A width at or above the total keeps hsync_no low for the entire line.
- R6: line_total_i, sync_width_i and sync_amp_i are sampled only at the enabled clock that starts a line. Changes in the middle of a line have no effect until the next line start.
- R7: A line total input of 0 or 1 is captured as 2, so the line still has two pixels.
- R8: level_o equals the captured amplitude times 3 while hsync_no is low, and 0 otherwise.
- R9: sync_clr_i high at a clock edge forces the count to 0 and sol_o low, whatever the value of pix_en_i. The captured settings are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel enable; the counter advances only when high |
| sync_clr_i | input | 1 | Synchronous clear to the idle pre-line state |
| line_total_i | input | 12 | Last count value of a line |
| sync_width_i | input | 8 | Sync pulse length in pixels |
| sync_amp_i | input | 8 | Sync amplitude code |
| hsync_no | output | 1 | Horizontal sync, active low |
| cnt_o | output | 12 | Current pixel count (0 when idle) |
| sol_o | output | 1 | Start-of-line strobe |
| level_o | output | 10 | Sync level for the DAC adder |

## Verification
The hardest case to reach from the ports is a settings change that lands inside a line, with the effect visible only on the following line. The mismatch is seen only when a stale or early capture changes the pulse length or the wrap point. The stimulus therefore keeps line totals short, so that many lines complete in a run. It also changes the three settings at random cycles, independent of line position. Directed segments add totals of 0 and 1, a zero width, a width longer than the line, and clears issued while the pixel enable is low.

// File: rtl/hsync_pkg.sv
package hsync_pkg;
  localparam int CNT_W     = 12;
  localparam int WID_W     = 8;
  localparam int AMP_W     = 8;
  localparam int SYNC_STEP = 3;
  localparam int STEP_W    = $clog2(SYNC_STEP + 1);
  localparam int LVL_W     = AMP_W + STEP_W;
endpackage

// File: rtl/hs_shadow.sv
module hs_shadow #(
  parameter int CNT_W = 12,
  parameter int WID_W = 8,
  parameter int AMP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] tot_i,
  input  logic [WID_W-1:0] wid_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic [CNT_W-1:0] tot_o,
  output logic [WID_W-1:0] wid_o,
  output logic [AMP_W-1:0] amp_o
);
  localparam logic [CNT_W-1:0] MIN_TOT = CNT_W'(2);

  logic [CNT_W-1:0] tot_clamped;
  assign tot_clamped = (tot_i < MIN_TOT) ? MIN_TOT : tot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tot_o <= MIN_TOT;
      wid_o <= '0;
      amp_o <= '0;
    end else if (load_i) begin
      tot_o <= tot_clamped;
      wid_o <= wid_i;
      amp_o <= amp_i;
    end
  end
endmodule

// File: rtl/hs_counter.sv
module hs_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] tot_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o,
  output logic             sol_o
);
  logic wrap;
  assign wrap    = (cnt_o == '0) || (cnt_o >= tot_i);
  assign start_o = en_i && !clr_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      sol_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o <= '0;
      sol_o <= 1'b0;
    end else begin
      sol_o <= start_o;
      if (start_o)   cnt_o <= CNT_W'(1);
      else if (en_i) cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/hs_sync_out.sv
module hs_sync_out #(
  parameter int CNT_W     = 12,
  parameter int WID_W     = 8,
  parameter int AMP_W     = 8,
  parameter int SYNC_STEP = 3,
  parameter int LVL_W     = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [WID_W-1:0] wid_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic             hsync_no,
  output logic [LVL_W-1:0] level_o
);
  logic active;
  // count is at least 12 bits wide, width fits after zero-extension
  assign active   = (cnt_i != '0) && (cnt_i <= CNT_W'(wid_i));
  assign hsync_no = !active;
  assign level_o  = active ? (LVL_W'(amp_i) * LVL_W'(SYNC_STEP)) : '0;
endmodule

// File: rtl/hsync_gen.sv
module hsync_gen
  import hsync_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  input  logic             sync_clr_i,
  input  logic [CNT_W-1:0] line_total_i,
  input  logic [WID_W-1:0] sync_width_i,
  input  logic [AMP_W-1:0] sync_amp_i,
  output logic             hsync_no,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sol_o,
  output logic [LVL_W-1:0] level_o
);
  logic [CNT_W-1:0] tot_q;
  logic [WID_W-1:0] wid_q;
  logic [AMP_W-1:0] amp_q;
  logic             start;

  hs_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (pix_en_i),
    .clr_i   (sync_clr_i),
    .tot_i   (tot_q),
    .cnt_o   (cnt_o),
    .start_o (start),
    .sol_o   (sol_o)
  );

  hs_shadow #(.CNT_W(CNT_W), .WID_W(WID_W), .AMP_W(AMP_W)) u_shd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .tot_i  (line_total_i),
    .wid_i  (sync_width_i),
    .amp_i  (sync_amp_i),
    .tot_o  (tot_q),
    .wid_o  (wid_q),
    .amp_o  (amp_q)
  );

  hs_sync_out #(.CNT_W(CNT_W), .WID_W(WID_W), .AMP_W(AMP_W),
                .SYNC_STEP(SYNC_STEP), .LVL_W(LVL_W)) u_out (
    .cnt_i    (cnt_o),
    .wid_i    (wid_q),
    .amp_i    (amp_q),
    .hsync_no (hsync_no),
    .level_o  (level_o)
  );
endmodule

// File: rtl/hsync_gen_chk.sv
module hsync_gen_chk
  import hsync_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_en_i,
  input logic             sync_clr_i,
  input logic             hsync_no,
  input logic [CNT_W-1:0] cnt_o,
  input logic             sol_o,
  input logic [LVL_W-1:0] level_o,
  input logic [CNT_W-1:0] tot_q,
  input logic [WID_W-1:0] wid_q
);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (cnt_o == '0 && !sol_o && hsync_no));

  assert_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && !sync_clr_i && (cnt_o == '0 || cnt_o == tot_q))
      |=> (cnt_o == CNT_W'(1) && sol_o));

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && !sync_clr_i && cnt_o != '0 && cnt_o < tot_q)
      |=> (cnt_o == $past(cnt_o) + CNT_W'(1) && !sol_o));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pix_en_i && !sync_clr_i) |=> ($stable(cnt_o) && !sol_o));

  assert_sync_at_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sol_o && wid_q != '0) |-> !hsync_no);

  assert_zero_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wid_q == '0) |-> hsync_no);

  assert_min_total_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tot_q >= CNT_W'(2) && cnt_o <= tot_q);

  assert_level_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_no |-> (level_o == '0));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_i |=> (cnt_o == '0 && !sol_o));
endmodule

bind hsync_gen hsync_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_en_i   (pix_en_i),
  .sync_clr_i (sync_clr_i),
  .hsync_no   (hsync_no),
  .cnt_o      (cnt_o),
  .sol_o      (sol_o),
  .level_o    (level_o),
  .tot_q      (tot_q),
  .wid_q      (wid_q)
);

// File: tb/sim_hsync_gen.sv
module sim_hsync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, clr = 1'b0;
  logic [11:0] tot_in = 12'd8;
  logic [7:0]  wid_in = 8'd3, amp_in = 8'd10;
  logic        hs_n, sol;
  logic [11:0] cnt;
  logic [9:0]  lvl;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench reference state
  int m_cnt, m_tot, m_wid, m_amp;
  bit m_sol;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsync_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(en), .sync_clr_i(clr),
    .line_total_i(tot_in), .sync_width_i(wid_in), .sync_amp_i(amp_in),
    .hsync_no(hs_n), .cnt_o(cnt), .sol_o(sol), .level_o(lvl)
  );

  function automatic bit exp_active(int c, int w);
    return (c != 0) && (c <= w);
  endfunction

  function automatic int clamp_tot(int t);
    return (t < 2) ? 2 : t;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_tot = 2; m_wid = 0; m_amp = 0; m_sol = 0;
  endtask

  task automatic model_step();
    if (clr) begin
      m_cnt = 0; m_sol = 0;                         // R9
    end else if (en && (m_cnt == 0 || m_cnt >= m_tot)) begin
      m_cnt = 1; m_sol = 1;                         // R2
      m_tot = clamp_tot(int'(tot_in));              // R6, R7
      m_wid = int'(wid_in);
      m_amp = int'(amp_in);
    end else begin
      if (en) m_cnt = m_cnt + 1;                    // R3
      m_sol = 0;
    end
  endtask

  task automatic check(string tag);
    bit act;
    act = exp_active(m_cnt, m_wid);
    n_vec++;
    if (int'(cnt) != m_cnt) begin
      n_bad++; $display("FAIL %s R3 count: got %0d exp %0d", tag, cnt, m_cnt);
    end
    if (sol != m_sol) begin
      n_bad++; $display("FAIL %s R2 sol: got %0b exp %0b", tag, sol, m_sol);
    end
    if (hs_n != !act) begin
      n_bad++; $display("FAIL %s R4 hsync_n: got %0b exp %0b", tag, hs_n, !act);
    end
    if (int'(lvl) != (act ? m_amp * 3 : 0)) begin
      n_bad++; $display("FAIL %s R8 level: got %0d exp %0d", tag, lvl, act ? m_amp * 3 : 0);
    end
  endtask

  // drive inputs at negedge, sample one half period after the edge
  task automatic cycle(bit e, bit c, string tag);
    en = e; clr = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  task automatic set_cfg(int t, int w, int a);
    tot_in = 12'(t); wid_in = 8'(w); amp_in = 8'(a);
  endtask

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset held");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");
    cycle(0, 0, "R3 idle hold");

    // basic lines: total 6, width 2, amp 10
    set_cfg(6, 2, 10);
    repeat (14) cycle(1, 0, "R2 R4 basic");
    // mid-line change, visible only next line
    repeat (2) cycle(1, 0, "R6 pre");
    set_cfg(4, 4, 20);
    repeat (12) cycle(1, 0, "R6 mid-line change");
    // zero width
    set_cfg(5, 0, 50);
    repeat (12) cycle(1, 0, "R5 zero width");
    // width beyond total
    set_cfg(3, 9, 7);
    repeat (10) cycle(1, 0, "R5 wide pulse");
    // total 0 and 1 clamp to 2
    set_cfg(0, 1, 1);
    repeat (8) cycle(1, 0, "R7 total 0");
    set_cfg(1, 1, 2);
    repeat (8) cycle(1, 0, "R7 total 1");
    // stalled enable, then clear with enable low
    set_cfg(9, 3, 255);
    repeat (4) cycle(1, 0, "R3 run");
    repeat (3) cycle(0, 0, "R3 hold");
    cycle(0, 1, "R9 clear en low");
    cycle(0, 0, "R9 stay idle");
    repeat (6) cycle(1, 0, "R2 restart");
    cycle(1, 1, "R9 clear en high");
    // max total briefly
    set_cfg(4095, 255, 128);
    repeat (300) cycle(1, 0, "R4 long line");

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 23 == 0)
        set_cfg($urandom % 40, $urandom % 48, $urandom % 256);
      cycle(($urandom % 4) != 0, ($urandom % 300) == 0, "rand");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule